// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block walks a list of transmit descriptors in memory once software raises its run enable. Each descriptor is four 32-bit words and is fetched through a simple request/response port. The walker looks at the ownership flag in the first word. If the DMA side owns the descriptor, the walker hands the buffer pointer and control word to a data mover as a one-cycle pulse. It then writes the first word back with ownership returned to software, and moves on to the next descriptor. If software owns the descriptor, the walker parks in a suspended state and flags that no buffer is available. A poll-demand pulse makes it fetch the same descriptor again.

Each descriptor chooses how to reach the next one. It can follow an explicit pointer held in the fourth word. It can jump back to the list base at the end of a ring. Otherwise it steps by 16 bytes. An error response on either the fetch or the writeback stops the walker for good: it raises a fatal status with an error code, and only a reset clears it.

Top module: `txdesc_walker`

## Requirements
- R1: Out of reset, `status` is 0 (stopped), no fetch or writeback request is raised, and `buf_go`, `buf_unavail` and `fatal_err` are low with `err_code` 0.
- R2: In the stopped state, a high `start_en` makes the walker request a fetch at `list_base` in the next cycle. `status` becomes 1 (running).
- R3: A fetched descriptor whose first-word bit 31 is 1 is owned by the DMA. In the cycle after its response, `buf_go` is high for exactly one cycle, with `buf_ptr` equal to word 2 and `buf_ctl` equal to word 1. Word 0 sits in `rd_data[31:0]`, word 1 in `[63:32]`, and so on.
- R4: After an owned descriptor is handed off, a writeback request is raised to the descriptor's address. It carries word 0 with bit 31 cleared, and it completes before the next fetch. Fetch and writeback requests are never high together.
- R5: When first-word bit 20 is 0, the next descriptor address is the current address plus 16. If bit 21 is 1 instead, the next address is `list_base`.
- R6: When first-word bit 20 is 1, the next descriptor address is word 3, whatever bit 21 holds.
- R7: A fetched descriptor whose bit 31 is 0 moves the walker to `status` 2 (suspended) and sets `buf_unavail`. No handoff and no writeback follow, and no request is raised while suspended.
- R8: In the suspended state, with `start_en` high, a `poll_demand` pulse fetches again at the same descriptor address and clears `buf_unavail`.
- R9: Dropping `start_en` takes the walker to stopped. This happens at once when suspended, and after the outstanding fetch or writeback completes otherwise. A later start begins again at `list_base`.
- R10: An error response to a fetch or to a writeback moves the walker to `status` 3 with `fatal_err` high. `err_code` is 1 for a fetch error and 2 for a writeback error. The walker then raises no request and ignores `start_en` and `poll_demand` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_en | input | 1 | Run enable from the operation control register |
| poll_demand | input | 1 | One-cycle request to re-fetch while suspended |
| list_base | input | ADDR_W | Address of the first descriptor of the list |
| rd_req | output | 1 | Descriptor fetch request, held until answered |
| rd_addr | output | ADDR_W | Address of the descriptor being fetched |
| rd_ack | input | 1 | Fetch response valid, `rd_data` carries the descriptor |
| rd_err | input | 1 | Fetch answered with an error |
| rd_data | input | 128 | Four descriptor words, word 0 in the low bits |
| wb_req | output | 1 | Status writeback request, held until answered |
| wb_addr | output | ADDR_W | Address of the descriptor written back |
| wb_data | output | 32 | First word with ownership cleared |
| wb_ack | input | 1 | Writeback completed |
| wb_err | input | 1 | Writeback answered with an error |
| buf_go | output | 1 | One-cycle buffer handoff to the data mover |
| buf_ptr | output | ADDR_W | Buffer address from word 2 |
| buf_ctl | output | 32 | Control/length word from word 1 |
| status | output | 2 | 0 stopped, 1 running, 2 suspended, 3 fatal |
| buf_unavail | output | 1 | Set on suspend, cleared on leaving it |
| fatal_err | output | 1 | Fatal bus error latched |
| err_code | output | 2 | 0 none, 1 fetch error, 2 writeback error |

## Verification
Every result of the walker is due exactly one clock after the edge that samples its cause. A fetch request and `status` 1 follow the start edge. `buf_go` and the writeback request follow an owned response. The next fetch follows the writeback acknowledge. `status` 2 or 3 follows a non-owned response or an error. The bench holds a behavioural model that advances on the same rising edge as the design. It compares every output against that model at the falling edge of every cycle, so each expected value is checked in the one cycle it is due. A memory responder answers each request one cycle after seeing it, and drops its answer the cycle after that. Scenario checks then confirm ownership writebacks in memory and the address reached by ring wrap and chain jumps.

// File: rtl/txdw_pkg.sv
package txdw_pkg;
    localparam int WORD_W     = 32;
    localparam int NWORDS     = 4;
    localparam int DESC_W     = WORD_W * NWORDS;
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 21;
    localparam int CHAIN_BIT  = 20;
    localparam int DESC_BYTES = NWORDS * WORD_W / 8;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_FETCH,
        ST_WBACK,
        ST_SUSP,
        ST_FATAL
    } walk_state_e;

    typedef enum logic [1:0] {
        STS_STOPPED = 2'd0,
        STS_RUN     = 2'd1,
        STS_SUSP    = 2'd2,
        STS_FATAL   = 2'd3
    } walk_status_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_FETCH = 2'd1,
        ERR_WBACK = 2'd2
    } bus_err_e;

    typedef struct packed {
        logic [WORD_W-1:0] w3;
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w0;
    } desc_t;

    function automatic walk_status_e status_of(walk_state_e s);
        case (s)
            ST_FETCH, ST_WBACK: return STS_RUN;
            ST_SUSP:            return STS_SUSP;
            ST_FATAL:           return STS_FATAL;
            default:            return STS_STOPPED;
        endcase
    endfunction
endpackage

// File: rtl/txdw_desc_reg.sv
module txdw_desc_reg
    import txdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DESC_W-1:0] data,
    output desc_t             q
);
    logic [WORD_W-1:0] word_q [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[i] <= '0;
            end else if (load) begin
                word_q[i] <= data[i*WORD_W +: WORD_W];
            end
        end
    end

    assign q = '{w3: word_q[3], w2: word_q[2], w1: word_q[1], w0: word_q[0]};
endmodule

// File: rtl/txdw_next_addr.sv
module txdw_next_addr
    import txdw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  desc_t             desc,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    logic chained;
    logic ring_end;

    assign chained  = desc.w0[CHAIN_BIT];
    assign ring_end = desc.w0[EOR_BIT];

    always_comb begin
        if (chained) begin
            next_addr = desc.w3[ADDR_W-1:0];
        end else if (ring_end) begin
            next_addr = base_addr;
        end else begin
            next_addr = cur_addr + STEP;
        end
    end
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
    import txdw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_en,
    input  logic              poll_demand,
    input  logic [ADDR_W-1:0] list_base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic              rd_err,
    input  logic [DESC_W-1:0] rd_data,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [WORD_W-1:0] wb_data,
    input  logic              wb_ack,
    input  logic              wb_err,
    output logic              buf_go,
    output logic [ADDR_W-1:0] buf_ptr,
    output logic [WORD_W-1:0] buf_ctl,
    output logic [1:0]        status,
    output logic              buf_unavail,
    output logic              fatal_err,
    output logic [1:0]        err_code
);
    walk_state_e       state_q;
    bus_err_e          err_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] next_addr;
    logic              go_q;
    logic              unavail_q;
    logic              fetch_done;
    desc_t             desc_q;

    assign fetch_done = (state_q == ST_FETCH) && rd_ack && !rd_err;

    txdw_desc_reg u_desc (
        .clk  (clk),
        .rst  (rst),
        .load (fetch_done),
        .data (rd_data),
        .q    (desc_q)
    );

    txdw_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur_addr  (cur_q),
        .base_addr (list_base),
        .desc      (desc_q),
        .next_addr (next_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_STOP;
            err_q     <= ERR_NONE;
            cur_q     <= '0;
            go_q      <= 1'b0;
            unavail_q <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (state_q)
                ST_STOP: begin
                    if (start_en) begin
                        cur_q   <= list_base;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (rd_err) begin
                        err_q   <= ERR_FETCH;
                        state_q <= ST_FATAL;
                    end else if (rd_ack) begin
                        if (!start_en) begin
                            state_q <= ST_STOP;
                        end else if (rd_data[OWN_BIT]) begin
                            go_q    <= 1'b1;
                            state_q <= ST_WBACK;
                        end else begin
                            unavail_q <= 1'b1;
                            state_q   <= ST_SUSP;
                        end
                    end
                end
                ST_WBACK: begin
                    if (wb_err) begin
                        err_q   <= ERR_WBACK;
                        state_q <= ST_FATAL;
                    end else if (wb_ack) begin
                        cur_q   <= next_addr;
                        state_q <= start_en ? ST_FETCH : ST_STOP;
                    end
                end
                ST_SUSP: begin
                    if (!start_en) begin
                        unavail_q <= 1'b0;
                        state_q   <= ST_STOP;
                    end else if (poll_demand) begin
                        unavail_q <= 1'b0;
                        state_q   <= ST_FETCH;
                    end
                end
                default: state_q <= ST_FATAL;
            endcase
        end
    end

    assign rd_req      = (state_q == ST_FETCH);
    assign rd_addr     = cur_q;
    assign wb_req      = (state_q == ST_WBACK);
    assign wb_addr     = cur_q;
    assign wb_data     = {1'b0, desc_q.w0[OWN_BIT-1:0]};
    assign buf_go      = go_q;
    assign buf_ptr     = desc_q.w2[ADDR_W-1:0];
    assign buf_ctl     = desc_q.w1;
    assign status      = status_of(state_q);
    assign buf_unavail = unavail_q;
    assign fatal_err   = (state_q == ST_FATAL);
    assign err_code    = err_q;
endmodule

// File: rtl/txdw_checker.sv
module txdw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start_en,
    input logic              poll_demand,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              rd_err,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wb_req,
    input logic              buf_go,
    input logic [1:0]        status,
    input logic              fatal_err
);
    assert_start_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd0 && start_en) |=> rd_req);

    assert_go_single_R3: assert property (@(posedge clk) disable iff (rst)
        buf_go |=> !buf_go);

    assert_go_then_wb_R4: assert property (@(posedge clk) disable iff (rst)
        buf_go |-> wb_req);

    assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wb_req));

    assert_susp_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2) |-> (!rd_req && !wb_req));

    assert_poll_refetch_R8: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2 && start_en && poll_demand) |=> rd_req);

    assert_fetch_held_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && !rd_err) |=> (rd_req && $stable(rd_addr)));

    assert_fatal_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd3) |=> (status == 2'd3 && fatal_err));

    assert_fatal_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        fatal_err |-> (!rd_req && !wb_req));
endmodule

bind txdesc_walker txdw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_en    (start_en),
    .poll_demand (poll_demand),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .rd_err      (rd_err),
    .rd_addr     (rd_addr),
    .wb_req      (wb_req),
    .buf_go      (buf_go),
    .status      (status),
    .fatal_err   (fatal_err)
);

// File: tb/sim_txdesc_walker.sv
module sim_txdesc_walker;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_en = 1'b0;
    logic          poll_demand = 1'b0;
    logic [AW-1:0] list_base = 32'h100;
    logic          rd_req, wb_req, buf_go, buf_unavail, fatal_err;
    logic [AW-1:0] rd_addr, wb_addr, buf_ptr;
    logic          rd_ack = 1'b0, rd_err = 1'b0, wb_ack = 1'b0, wb_err = 1'b0;
    logic [127:0]  rd_data = '0;
    logic [31:0]   wb_data, buf_ctl;
    logic [1:0]    status, err_code;

    always #2 clk = ~clk;

    txdesc_walker #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .start_en(start_en), .poll_demand(poll_demand),
        .list_base(list_base), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data),
        .wb_ack(wb_ack), .wb_err(wb_err), .buf_go(buf_go),
        .buf_ptr(buf_ptr), .buf_ctl(buf_ctl), .status(status),
        .buf_unavail(buf_unavail), .fatal_err(fatal_err), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // descriptor memory, 16 slots of 16 bytes from address 0x100
    logic [127:0] mem [16];
    bit           rd_err_armed = 0;
    bit           wb_err_armed = 0;

    function automatic logic [127:0] mkd(bit own, bit chain, bit eor, logic [31:0] w1,
                                          logic [31:0] w2, logic [31:0] w3);
        logic [31:0] w0;
        w0 = 32'h0000_0A05;
        w0[31] = own;
        w0[21] = eor;
        w0[20] = chain;
        return {w3, w2, w1, w0};
    endfunction

    // responder: answers one cycle after a request is seen, drops the answer next cycle
    always @(negedge clk) begin
        if (rst || rd_ack || rd_err) begin
            rd_ack = 0;
            rd_err = 0;
        end else if (rd_req) begin
            if (rd_err_armed) rd_err = 1;
            else begin
                rd_ack  = 1;
                rd_data = mem[rd_addr[7:4]];
            end
        end
        if (rst || wb_ack || wb_err) begin
            wb_ack = 0;
            wb_err = 0;
        end else if (wb_req) begin
            if (wb_err_armed) wb_err = 1;
            else begin
                wb_ack = 1;
                mem[wb_addr[7:4]][31] = 1'b0;
            end
        end
    end

    // behavioural reference: 0 stop, 1 fetching, 2 writing back, 3 suspended, 4 fatal
    int           m_state;
    logic [31:0]  m_cur;
    logic [127:0] m_desc;
    bit           m_go, m_un;
    int           m_err;

    always @(posedge clk) begin
        live = 1;
        if (rst) begin
            m_state = 0; m_cur = 0; m_desc = '0; m_go = 0; m_un = 0; m_err = 0;
        end else begin
            m_go = 0;
            case (m_state)
                0: if (start_en) begin m_cur = list_base; m_state = 1; end
                1: if (rd_err) begin m_state = 4; m_err = 1; end
                   else if (rd_ack) begin
                       if (!start_en) m_state = 0;
                       else begin
                           m_desc = rd_data;
                           if (rd_data[31]) begin m_state = 2; m_go = 1; end
                           else begin m_state = 3; m_un = 1; end
                       end
                   end
                2: if (wb_err) begin m_state = 4; m_err = 2; end
                   else if (wb_ack) begin
                       if (m_desc[20]) m_cur = m_desc[127:96];
                       else if (m_desc[21]) m_cur = list_base;
                       else m_cur = m_cur + 16;
                       m_state = start_en ? 1 : 0;
                   end
                3: if (!start_en) begin m_state = 0; m_un = 0; end
                   else if (poll_demand) begin m_state = 1; m_un = 0; end
                default: m_state = 4;
            endcase
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            logic [1:0] es;
            es = (m_state == 0) ? 2'd0 : (m_state == 3) ? 2'd2 : (m_state == 4) ? 2'd3 : 2'd1;
            chk(status == es, "R2 R7 R8 R9 status", status, es);
            chk(rd_req == (m_state == 1), "R2 R5 R6 fetch request", rd_req, m_state == 1);
            if (m_state == 1) chk(rd_addr == m_cur, "R2 R5 R6 fetch address", rd_addr, m_cur);
            chk(wb_req == (m_state == 2), "R4 writeback request", wb_req, m_state == 2);
            if (m_state == 2) begin
                chk(wb_addr == m_cur, "R4 writeback address", wb_addr, m_cur);
                chk(wb_data == {1'b0, m_desc[30:0]}, "R4 writeback data", wb_data, {1'b0, m_desc[30:0]});
            end
            chk(buf_go == m_go, "R3 handoff pulse", buf_go, m_go);
            if (m_go) begin
                chk(buf_ptr == m_desc[95:64], "R3 buffer pointer", buf_ptr, m_desc[95:64]);
                chk(buf_ctl == m_desc[63:32], "R3 buffer control", buf_ctl, m_desc[63:32]);
            end
            chk(buf_unavail == m_un, "R7 R8 unavailable flag", buf_unavail, m_un);
            chk(fatal_err == (m_state == 4), "R10 fatal flag", fatal_err, m_state == 4);
            chk(err_code == 2'(m_err), "R10 error code", err_code, m_err);
        end
    end

    task automatic wait_status(input logic [1:0] s);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (status == s) break;
        end
    endtask

    task automatic do_reset();
        rst = 1; start_en = 0; poll_demand = 0;
        rd_err_armed = 0; wb_err_armed = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        do_reset();
        // R1 reset state
        chk(status == 2'd0 && !rd_req && !wb_req, "R1 reset idle", {status, rd_req, wb_req}, 0);
        chk(!buf_go && !buf_unavail && !fatal_err && err_code == 0, "R1 reset flags",
            {buf_go, buf_unavail, fatal_err, err_code}, 0);

        // ring step, chain jump, ring end back to base, then suspend on cleared slot 0
        mem[0] = mkd(1, 0, 0, 32'h0000_0064, 32'hA000, 32'h0);
        mem[1] = mkd(1, 1, 0, 32'h0000_0080, 32'hB000, 32'h150);
        mem[5] = mkd(1, 0, 1, 32'h0000_0020, 32'hC000, 32'h0);
        start_en = 1;
        wait_status(2'd2);
        chk(rd_addr == 32'h100, "R5 ring end returns to base", rd_addr, 32'h100);
        chk(mem[0][31] == 0 && mem[1][31] == 0 && mem[5][31] == 0, "R4 ownership returned",
            {mem[0][31], mem[1][31], mem[5][31]}, 0);
        chk(buf_unavail == 1, "R7 unavailable on owned-by-cpu", buf_unavail, 1);

        // chain bit wins over ring end; suspend at chained target
        mem[0] = mkd(1, 1, 1, 32'h0000_0010, 32'hD000, 32'h130);
        mem[3] = mkd(0, 0, 0, 32'h0, 32'h0, 32'h0);
        poll_demand = 1;
        @(negedge clk);
        poll_demand = 0;
        chk(rd_req == 1 && rd_addr == 32'h100, "R8 poll refetches same address", rd_addr, 32'h100);
        wait_status(2'd2);
        chk(rd_addr == 32'h130, "R6 chained next address", rd_addr, 32'h130);

        // stop while suspended, then restart from base
        start_en = 0;
        @(negedge clk);
        chk(status == 2'd0, "R9 stop from suspend", status, 0);
        mem[0] = mkd(1, 0, 0, 32'h1, 32'hE000, 32'h0);
        mem[1] = mkd(1, 0, 0, 32'h2, 32'hF000, 32'h0);
        start_en = 1;
        @(negedge clk);
        chk(rd_addr == 32'h100, "R9 restart at base", rd_addr, 32'h100);
        for (int i = 0; i < 20; i++) begin
            if (wb_req) break;
            @(negedge clk);
        end
        start_en = 0;
        wait_status(2'd0);
        chk(mem[0][31] == 0 && mem[1][31] == 1, "R9 stop after writeback completes",
            {mem[0][31], mem[1][31]}, 2'b01);

        // fetch error is fatal and sticky
        do_reset();
        mem[0] = mkd(1, 0, 0, 32'h1, 32'h1000, 32'h0);
        rd_err_armed = 1;
        start_en = 1;
        wait_status(2'd3);
        chk(err_code == 2'd1 && fatal_err, "R10 fetch error code", err_code, 1);
        rd_err_armed = 0;
        for (int i = 0; i < 4; i++) begin
            poll_demand = i[0];
            start_en = ~i[0];
            @(negedge clk);
        end
        poll_demand = 0;
        chk(status == 2'd3 && !rd_req && !wb_req, "R10 fatal ignores start and poll", status, 3);

        // writeback error
        do_reset();
        mem[0] = mkd(1, 0, 0, 32'h1, 32'h1000, 32'h0);
        wb_err_armed = 1;
        start_en = 1;
        wait_status(2'd3);
        chk(err_code == 2'd2 && fatal_err, "R10 writeback error code", err_code, 2);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule